// File: doc/BRIEF.md
# Exchange-and-Add Execution Unit

This unit runs one exchange-and-add step for an integer execution pipeline. Each request supplies a destination operand and a source register. The unit adds the two values. The source register then takes the old destination value, and the destination takes the sum. Along with the sum it produces carry, parity, half-carry, zero, sign and overflow status, all evaluated at the selected operand width. The operand width is 8, 16, 32 or 64 bits. It comes from the second opcode byte and the prefix indicators.

The unit also maps byte-register encodings to a physical register and a byte lane. It drives the read indices for the register file combinationally, so the caller can return the full register contents in the same cycle. The unit then merges each result back into the full 64-bit register image, following the width rules.

An atomic request whose destination is a register is rejected, as is an unknown opcode byte. In both cases the unit raises an invalid-opcode indication and writes nothing. All results appear one cycle after a `start` pulse.

Top module: `xchg_add_unit`

## Requirements
- R1: One cycle after `start`, `done` is 1 for one cycle. On a legal request `wr_en` is also 1, `dst_out` carries the sum and `src_out` carries the old destination operand, both merged as in R8.
- R2: Opcode 8'hC0 selects 8 bits. Opcode 8'hC1 selects 32 bits by default and 16 bits when `pfx_opsz` is set. When `long_mode` and `pfx_wide` are both set it selects 64 bits, and this takes precedence over `pfx_opsz`. Outside `long_mode`, `pfx_wide` is ignored.
- R3: `flags_out` bit 0 is carry out of the top bit of the selected width. Bit 3 is zero, bit 4 is the sign bit and bit 5 is signed overflow: both operands have the same sign and the sum's sign differs. All four are evaluated at the selected width.
- R4: `flags_out` bit 1 is 1 when the low 8 bits of the sum hold an even number of ones. Bit 2 is the carry out of bit 3 of the addition.
- R5: When `pfx_atomic` is set and `dst_is_mem` is 0, the result is `done`=1, `ud`=1 and `wr_en`=0, and `dst_out`, `src_out` and `flags_out` keep their previous values. With `dst_is_mem`=1, an atomic request executes normally.
- R6: Any opcode byte other than 8'hC0 or 8'hC1 gives `ud`=1 and `wr_en`=0 with `done`=1.
- R7: In an 8-bit operation on a register, encodings 4 to 7 normally select bits 15:8 of register (encoding − 4). When `long_mode` and `pfx_ext` are both set, they select bits 7:0 of the register with that encoding. `dst_rd_idx`, `src_rd_idx`, `dst_wr_idx` and `src_wr_idx` give the physical register.
- R8: 8-bit and 16-bit register writes keep the untouched bits of the register. A 32-bit register write clears bits 63:32 in `long_mode` and keeps them outside it. A memory destination gets the sum zero-extended to 64 bits, and `dst_wr_idx` is 0.
- R9: In a cycle without `start`, the next cycle has `done`=0 and `wr_en`=0, and all data outputs hold.
- R10: While `rst` is high, `done`, `ud` and `wr_en` are 0, and all data and index outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| opcode | input | 8 | Second opcode byte |
| long_mode | input | 1 | 64-bit execution mode |
| pfx_ext | input | 1 | Register-extension prefix present |
| pfx_wide | input | 1 | 64-bit promotion prefix bit |
| pfx_opsz | input | 1 | Operand-size override |
| pfx_atomic | input | 1 | Atomic-execution prefix |
| dst_is_mem | input | 1 | Destination is a memory operand |
| dst_enc | input | 4 | Destination register encoding |
| src_enc | input | 4 | Source register encoding |
| dst_rd_idx | output | 4 | Physical register to read for the destination |
| src_rd_idx | output | 4 | Physical register to read for the source |
| dst_val | input | 64 | Destination register contents or memory data |
| src_val | input | 64 | Source register contents |
| done | output | 1 | Result valid |
| ud | output | 1 | Invalid-opcode indication |
| wr_en | output | 1 | Results are to be written |
| dst_wr_idx | output | 4 | Physical register for the destination write |
| dst_out | output | 64 | New destination value |
| src_wr_idx | output | 4 | Physical register for the source write |
| src_out | output | 64 | New source register value |
| flags_out | output | 6 | {overflow, sign, zero, half, parity, carry} |

## Verification
The exchange is driven at every width, with operands that tell widths apart. An all-ones low half plus one wraps to zero at 16 or 32 bits but not at 64 bits, so a wrong width choice changes both the sum and the zero flag. Patterns are picked to isolate each flag: signed overflow from 7F-style values, carry with half-carry from all-ones plus one, and parity from sums with an odd or even count of ones.

Byte operations use encodings 4 and 7, with and without the extension prefix, and the surrounding bytes are filled with distinct values. This separates a lane or index error from a merge error. Rejected requests follow a legal one with known outputs, so any write leaking through is visible.

// File: rtl/xau_pkg.sv
package xau_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_QUAD = 2'd3
  } opsz_e;

  localparam logic [7:0] OPC_NARROW = 8'hC0;
  localparam logic [7:0] OPC_WIDE   = 8'hC1;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic half;
    logic parity;
    logic carry;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/xau_size_dec.sv
module xau_size_dec
  import xau_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       long_mode,
  input  logic       pfx_wide,
  input  logic       pfx_opsz,
  input  logic       pfx_atomic,
  input  logic       dst_is_mem,
  output opsz_e      size,
  output logic       illegal
);
  logic bad_opc;
  logic bad_atomic;

  always_comb begin
    size    = SZ_WORD;
    bad_opc = 1'b0;
    unique case (opcode)
      OPC_NARROW: size = SZ_BYTE;
      OPC_WIDE: begin
        if (long_mode && pfx_wide) size = SZ_QUAD;
        else if (pfx_opsz)         size = SZ_HALF;
        else                       size = SZ_WORD;
      end
      default: bad_opc = 1'b1;
    endcase
  end

  assign bad_atomic = pfx_atomic && !dst_is_mem;
  assign illegal    = bad_opc || bad_atomic;
endmodule

// File: rtl/xau_lane_map.sv
module xau_lane_map #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] enc,
  input  logic             is_byte,
  input  logic             ext_ok,
  input  logic             is_mem,
  output logic [IDX_W-1:0] phys_idx,
  output logic             hi_lane
);
  localparam int HI_BASE = 4;
  localparam int HI_TOP  = 7;

  logic in_hi_range;

  assign in_hi_range = (int'(enc) >= HI_BASE) && (int'(enc) <= HI_TOP);

  always_comb begin
    hi_lane  = 1'b0;
    phys_idx = enc;
    if (is_mem) begin
      phys_idx = '0;
    end else if (is_byte && !ext_ok && in_hi_range) begin
      hi_lane  = 1'b1;
      phys_idx = enc - IDX_W'(HI_BASE);
    end
  end
endmodule

// File: rtl/xau_add_flags.sv
module xau_add_flags
  import xau_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  opsz_e             size,
  output logic [DATA_W-1:0] sum,
  output flags_t            flags
);
  localparam int NUM_SZ = $clog2(DATA_W / 8) + 1;

  logic [DATA_W-1:0] sum_v [NUM_SZ];
  flags_t            flg_v [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
    localparam int W = 8 << g;
    logic [W:0]   full;
    logic [W-1:0] res;

    assign full = {1'b0, opa[W-1:0]} + {1'b0, opb[W-1:0]};
    assign res  = full[W-1:0];

    assign sum_v[g]        = DATA_W'(res);
    assign flg_v[g].carry  = full[W];
    assign flg_v[g].parity = ~^res[7:0];
    assign flg_v[g].half   = opa[4] ^ opb[4] ^ res[4];
    assign flg_v[g].zero   = (res == '0);
    assign flg_v[g].sign   = res[W-1];
    assign flg_v[g].ovf    = (opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1]);
  end

  assign sum   = sum_v[size];
  assign flags = flg_v[size];
endmodule

// File: rtl/xau_merge.sv
module xau_merge
  import xau_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] old_full,
  input  logic [DATA_W-1:0] newv,
  input  opsz_e             size,
  input  logic              hi_lane,
  input  logic              to_mem,
  input  logic              long_mode,
  output logic [DATA_W-1:0] merged
);
  localparam int HALF_D = DATA_W / 2;

  logic [DATA_W-1:0] masked;

  always_comb begin
    unique case (size)
      SZ_BYTE: masked = DATA_W'(newv[7:0]);
      SZ_HALF: masked = DATA_W'(newv[15:0]);
      SZ_WORD: masked = DATA_W'(newv[HALF_D-1:0]);
      default: masked = newv;
    endcase
  end

  always_comb begin
    merged = old_full;
    if (to_mem) begin
      merged = masked;
    end else begin
      unique case (size)
        SZ_BYTE: begin
          if (hi_lane) merged[15:8] = newv[7:0];
          else         merged[7:0]  = newv[7:0];
        end
        SZ_HALF: merged[15:0] = newv[15:0];
        SZ_WORD: begin
          if (long_mode) merged = masked;
          else           merged[HALF_D-1:0] = newv[HALF_D-1:0];
        end
        default: merged = newv;
      endcase
    end
  end
endmodule

// File: rtl/xchg_add_unit.sv
module xchg_add_unit
  import xau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              long_mode,
  input  logic              pfx_ext,
  input  logic              pfx_wide,
  input  logic              pfx_opsz,
  input  logic              pfx_atomic,
  input  logic              dst_is_mem,
  input  logic [IDX_W-1:0]  dst_enc,
  input  logic [IDX_W-1:0]  src_enc,
  output logic [IDX_W-1:0]  dst_rd_idx,
  output logic [IDX_W-1:0]  src_rd_idx,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  output logic              done,
  output logic              ud,
  output logic              wr_en,
  output logic [IDX_W-1:0]  dst_wr_idx,
  output logic [DATA_W-1:0] dst_out,
  output logic [IDX_W-1:0]  src_wr_idx,
  output logic [DATA_W-1:0] src_out,
  output logic [FLAG_W-1:0] flags_out
);
  opsz_e             size;
  logic              illegal;
  logic              ext_ok;
  logic              is_byte;
  logic              dst_hi;
  logic              src_hi;
  logic [IDX_W-1:0]  dst_idx;
  logic [IDX_W-1:0]  src_idx;
  logic [DATA_W-1:0] dst_opnd;
  logic [DATA_W-1:0] src_opnd;
  logic [DATA_W-1:0] sum;
  flags_t            flg;
  logic [DATA_W-1:0] dst_new;
  logic [DATA_W-1:0] src_new;
  logic              accept;

  xau_size_dec i_size (
    .opcode    (opcode),
    .long_mode (long_mode),
    .pfx_wide  (pfx_wide),
    .pfx_opsz  (pfx_opsz),
    .pfx_atomic(pfx_atomic),
    .dst_is_mem(dst_is_mem),
    .size      (size),
    .illegal   (illegal)
  );

  assign ext_ok  = long_mode && pfx_ext;
  assign is_byte = (size == SZ_BYTE);

  xau_lane_map #(.IDX_W(IDX_W)) i_dst_map (
    .enc     (dst_enc),
    .is_byte (is_byte),
    .ext_ok  (ext_ok),
    .is_mem  (dst_is_mem),
    .phys_idx(dst_idx),
    .hi_lane (dst_hi)
  );

  xau_lane_map #(.IDX_W(IDX_W)) i_src_map (
    .enc     (src_enc),
    .is_byte (is_byte),
    .ext_ok  (ext_ok),
    .is_mem  (1'b0),
    .phys_idx(src_idx),
    .hi_lane (src_hi)
  );

  assign dst_rd_idx = dst_idx;
  assign src_rd_idx = src_idx;

  assign dst_opnd = dst_hi ? (dst_val >> 8) : dst_val;
  assign src_opnd = src_hi ? (src_val >> 8) : src_val;

  xau_add_flags #(.DATA_W(DATA_W)) i_add (
    .opa  (dst_opnd),
    .opb  (src_opnd),
    .size (size),
    .sum  (sum),
    .flags(flg)
  );

  xau_merge #(.DATA_W(DATA_W)) i_dst_merge (
    .old_full (dst_val),
    .newv     (sum),
    .size     (size),
    .hi_lane  (dst_hi),
    .to_mem   (dst_is_mem),
    .long_mode(long_mode),
    .merged   (dst_new)
  );

  xau_merge #(.DATA_W(DATA_W)) i_src_merge (
    .old_full (src_val),
    .newv     (dst_opnd),
    .size     (size),
    .hi_lane  (src_hi),
    .to_mem   (1'b0),
    .long_mode(long_mode),
    .merged   (src_new)
  );

  assign accept = start && !illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      ud         <= 1'b0;
      wr_en      <= 1'b0;
      dst_wr_idx <= '0;
      src_wr_idx <= '0;
      dst_out    <= '0;
      src_out    <= '0;
      flags_out  <= '0;
    end else begin
      done  <= start;
      ud    <= start && illegal;
      wr_en <= accept;
      if (accept) begin
        dst_wr_idx <= dst_idx;
        src_wr_idx <= src_idx;
        dst_out    <= dst_new;
        src_out    <= src_new;
        flags_out  <= flg;
      end
    end
  end
endmodule

// File: rtl/xau_checker.sv
module xau_checker #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [7:0]        opcode,
  input logic              long_mode,
  input logic              pfx_wide,
  input logic              pfx_opsz,
  input logic              pfx_atomic,
  input logic              dst_is_mem,
  input logic              done,
  input logic              ud,
  input logic              wr_en,
  input logic [DATA_W-1:0] dst_out,
  input logic [DATA_W-1:0] src_out,
  input logic [5:0]        flags_out
);
  localparam int HALF_D = DATA_W / 2;

  a_r1_done_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  a_r1_legal_writes: assert property (@(posedge clk) disable iff (rst)
    (done && !ud) |-> wr_en);

  a_r5_reject_reg_atomic: assert property (@(posedge clk) disable iff (rst)
    (start && pfx_atomic && !dst_is_mem) |=> (ud && !wr_en));

  a_r5_reject_holds: assert property (@(posedge clk) disable iff (rst)
    (start && pfx_atomic && !dst_is_mem) |=>
      ($stable(dst_out) && $stable(src_out) && $stable(flags_out)));

  a_r6_ud_blocks_write: assert property (@(posedge clk) disable iff (rst)
    ud |-> (done && !wr_en));

  a_r8_word_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 8'hC1 && long_mode && !pfx_wide && !pfx_opsz
     && !pfx_atomic && !dst_is_mem) |=>
      (dst_out[DATA_W-1:HALF_D] == '0 && src_out[DATA_W-1:HALF_D] == '0));

  a_r8_byte_mem_ext: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 8'hC0 && dst_is_mem) |=> (dst_out[DATA_W-1:8] == '0));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && !wr_en && $stable(dst_out) && $stable(flags_out)));
endmodule

bind xchg_add_unit xau_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_xau_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .opcode    (opcode),
  .long_mode (long_mode),
  .pfx_wide  (pfx_wide),
  .pfx_opsz  (pfx_opsz),
  .pfx_atomic(pfx_atomic),
  .dst_is_mem(dst_is_mem),
  .done      (done),
  .ud        (ud),
  .wr_en     (wr_en),
  .dst_out   (dst_out),
  .src_out   (src_out),
  .flags_out (flags_out)
);

// File: tb/test_xchg_add_unit.sv
module test_xchg_add_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        long_mode = 1'b0;
  logic        pfx_ext = 1'b0;
  logic        pfx_wide = 1'b0;
  logic        pfx_opsz = 1'b0;
  logic        pfx_atomic = 1'b0;
  logic        dst_is_mem = 1'b0;
  logic [3:0]  dst_enc = 4'd0;
  logic [3:0]  src_enc = 4'd0;
  logic [3:0]  dst_rd_idx;
  logic [3:0]  src_rd_idx;
  logic [63:0] dst_val = 64'd0;
  logic [63:0] src_val = 64'd0;
  logic        done;
  logic        ud;
  logic        wr_en;
  logic [3:0]  dst_wr_idx;
  logic [63:0] dst_out;
  logic [3:0]  src_wr_idx;
  logic [63:0] src_out;
  logic [5:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xchg_add_unit i_xchg_add_unit (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .long_mode(long_mode),
    .pfx_ext(pfx_ext), .pfx_wide(pfx_wide), .pfx_opsz(pfx_opsz),
    .pfx_atomic(pfx_atomic), .dst_is_mem(dst_is_mem), .dst_enc(dst_enc),
    .src_enc(src_enc), .dst_rd_idx(dst_rd_idx), .src_rd_idx(src_rd_idx),
    .dst_val(dst_val), .src_val(src_val), .done(done), .ud(ud), .wr_en(wr_en),
    .dst_wr_idx(dst_wr_idx), .dst_out(dst_out), .src_wr_idx(src_wr_idx),
    .src_out(src_out), .flags_out(flags_out)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] opc, input logic lm, input logic ext,
                       input logic wide, input logic osz, input logic atom,
                       input logic mem, input logic [3:0] de, input logic [3:0] se,
                       input logic [63:0] dv, input logic [63:0] sv);
    @(negedge clk);
    opcode = opc; long_mode = lm; pfx_ext = ext; pfx_wide = wide;
    pfx_opsz = osz; pfx_atomic = atom; dst_is_mem = mem;
    dst_enc = de; src_enc = se; dst_val = dv; src_val = sv;
    start = 1'b1;
    #1;
  endtask

  task automatic fire;
    @(posedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic expect_ok(input string req, input logic [63:0] d,
                           input logic [63:0] s, input logic [5:0] f);
    check(req, "done", 64'(done), 64'd1);
    check(req, "wr_en", 64'(wr_en), 64'd1);
    check(req, "ud", 64'(ud), 64'd0);
    check(req, "dst_out", dst_out, d);
    check(req, "src_out", src_out, s);
    check(req, "flags", 64'(flags_out), 64'(f));
  endtask

  task automatic t_reset;
    check("R10", "done", 64'(done), 64'd0);
    check("R10", "wr_en", 64'(wr_en), 64'd0);
    check("R10", "dst_out", dst_out, 64'd0);
    check("R10", "flags", 64'(flags_out), 64'd0);
  endtask

  task automatic t_quad_basic;  // R1 R3
    apply(8'hC1, 1, 0, 1, 0, 0, 1, 4'd0, 4'd2, 64'd5, 64'd3);
    fire();
    expect_ok("R1", 64'd8, 64'd5, 6'h00);
  endtask

  task automatic t_byte_overflow;  // R2 R3 R4 R8
    apply(8'hC0, 1, 0, 0, 0, 0, 1, 4'd0, 4'd1,
          64'hFFFF_FFFF_FFFF_FF7F, 64'h1234_5678_9ABC_DE01);
    check("R7", "src_rd_idx", 64'(src_rd_idx), 64'd1);
    fire();
    expect_ok("R3", 64'h80, 64'h1234_5678_9ABC_DE7F, 6'h34);
    check("R8", "dst_wr_idx mem", 64'(dst_wr_idx), 64'd0);
  endtask

  task automatic t_half_carry_zero;  // R2 R3 R4
    apply(8'hC1, 1, 0, 0, 1, 0, 0, 4'd2, 4'd3,
          64'h1111_2222_3333_FFFF, 64'h0000_0000_0000_0001);
    fire();
    expect_ok("R4", 64'h1111_2222_3333_0000, 64'h0000_0000_0000_FFFF, 6'h0F);
    check("R7", "dst_wr_idx", 64'(dst_wr_idx), 64'd2);
    check("R7", "src_wr_idx", 64'(src_wr_idx), 64'd3);
  endtask

  task automatic t_word_long;  // R2 R8
    apply(8'hC1, 1, 0, 0, 0, 0, 0, 4'd5, 4'd6,
          64'hDEAD_BEEF_0000_0010, 64'hCAFE_F00D_0000_0020);
    fire();
    expect_ok("R8", 64'h30, 64'h10, 6'h02);
  endtask

  task automatic t_wide_ignored_legacy;  // R2 R8
    apply(8'hC1, 0, 0, 1, 0, 0, 0, 4'd1, 4'd2,
          64'h1234_5678_FFFF_FFFF, 64'h0000_0001_0000_0001);
    fire();
    expect_ok("R2", 64'h1234_5678_0000_0000, 64'h0000_0001_FFFF_FFFF, 6'h0F);
  endtask

  task automatic t_high_byte;  // R7
    apply(8'hC0, 1, 0, 0, 0, 0, 0, 4'd4, 4'd7,
          64'hAAAA_AAAA_AAAA_40CC, 64'h5555_5555_5555_02DD);
    check("R7", "dst_rd_idx hi", 64'(dst_rd_idx), 64'd0);
    check("R7", "src_rd_idx hi", 64'(src_rd_idx), 64'd3);
    fire();
    expect_ok("R7", 64'hAAAA_AAAA_AAAA_42CC, 64'h5555_5555_5555_40DD, 6'h02);
    check("R7", "dst_wr_idx hi", 64'(dst_wr_idx), 64'd0);
    check("R7", "src_wr_idx hi", 64'(src_wr_idx), 64'd3);
  endtask

  task automatic t_ext_low_byte;  // R7 R3 R4
    apply(8'hC0, 1, 1, 0, 0, 0, 0, 4'd4, 4'd7,
          64'hAAAA_AAAA_AAAA_40CC, 64'h5555_5555_5555_02DD);
    check("R7", "dst_rd_idx ext", 64'(dst_rd_idx), 64'd4);
    check("R7", "src_rd_idx ext", 64'(src_rd_idx), 64'd7);
    fire();
    expect_ok("R7", 64'hAAAA_AAAA_AAAA_40A9, 64'h5555_5555_5555_02CC, 6'h17);
  endtask

  task automatic t_atomic_reg;  // R5
    apply(8'hC1, 1, 0, 1, 0, 1, 0, 4'd1, 4'd2, 64'd9, 64'd9);
    fire();
    check("R5", "done", 64'(done), 64'd1);
    check("R5", "ud", 64'(ud), 64'd1);
    check("R5", "wr_en", 64'(wr_en), 64'd0);
    check("R5", "dst_out held", dst_out, 64'hAAAA_AAAA_AAAA_40A9);
    check("R5", "src_out held", src_out, 64'h5555_5555_5555_02CC);
    check("R5", "flags held", 64'(flags_out), 64'h17);
  endtask

  task automatic t_atomic_mem;  // R5
    apply(8'hC1, 1, 0, 1, 0, 1, 1, 4'd0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    fire();
    expect_ok("R5", 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 6'h0F);
  endtask

  task automatic t_bad_opcode;  // R6
    apply(8'h01, 1, 0, 0, 0, 0, 1, 4'd0, 4'd1, 64'd1, 64'd1);
    fire();
    check("R6", "ud", 64'(ud), 64'd1);
    check("R6", "wr_en", 64'(wr_en), 64'd0);
    check("R6", "dst_out held", dst_out, 64'd0);
  endtask

  task automatic t_idle;  // R9
    @(negedge clk);
    start = 1'b0; dst_val = 64'h1; src_val = 64'h2; opcode = 8'hC1;
    @(posedge clk);
    #1;
    check("R9", "done", 64'(done), 64'd0);
    check("R9", "wr_en", 64'(wr_en), 64'd0);
    check("R9", "dst_out held", dst_out, 64'd0);
  endtask

  task automatic t_quad_priority;  // R2
    apply(8'hC1, 1, 0, 1, 1, 0, 0, 4'd8, 4'd9,
          64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000);
    fire();
    expect_ok("R2", 64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 6'h02);
  endtask

  task automatic t_quad_overflow;  // R3
    apply(8'hC1, 1, 0, 1, 0, 0, 1, 4'd0, 4'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    fire();
    expect_ok("R3", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 6'h36);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_quad_basic();
    t_byte_overflow();
    t_half_carry_zero();
    t_word_long();
    t_wide_ignored_legacy();
    t_high_byte();
    t_ext_low_byte();
    t_atomic_reg();
    t_atomic_mem();
    t_bad_opcode();
    t_idle();
    t_quad_priority();
    t_quad_overflow();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule